// File: doc/BRIEF.md
# Keyboard and Display Bus Port

This block is a small peripheral that sits on a processor's byte bus and serves two character devices: a keyboard on the input side and a display on the output side. The processor sees four byte registers in a window of four consecutive addresses. They hold the received character, the character to show, a flag byte, and an interrupt-enable byte. Any bus cycle whose address falls outside the window is not claimed. Such a cycle changes nothing and reads back zero, so memory can serve those addresses.

Software polls the flag byte until the flag it needs is set, then moves a character. A read of the received character consumes it. A write of the outgoing character hands it to the display and marks the display busy until the display signals ready again. Each device also has an interrupt enable. The two enabled request bits are OR-ed onto one interrupt line. If a keystroke arrives before the previous one was read, the old character is replaced and a sticky overrun flag is set.

Top module: `kbdisp_port`

## Requirements
- R1: While reset is held and in the cycle after its release, the flag byte and the enable byte read 0, `irq` is 0 and `disp_load` is 0.
- R2: A cycle is claimed (`bus_hit`=1) only when `bus_sel`=1 and `bus_addr` lies in BASE..BASE+3. An unclaimed cycle reads 0 and writes nothing. Offsets: 0 received character, 1 outgoing character, 2 flags, 3 enables.
- R3: A cycle with `kbd_valid`=1 loads `kbd_data` into the received-character register and sets the character-waiting flag (flag bit 0) from the next cycle on.
- R4: A read at offset 0 returns the stored character and clears flag bit 0.
- R5: A keystroke that arrives while flag bit 0 is set replaces the stored character and sets the overrun flag (flag bit 4). A read at offset 2 returns that bit and then clears it.
- R6: A write at offset 1 drives `disp_data` with the written byte, pulses `disp_load` high for exactly the cycle after the write, and clears the display-free flag (flag bit 1).
- R7: Flag bit 1 is set in the cycle after a cycle in which `disp_ready` is sampled high having been low (or having been in reset) on the previous edge.
- R8: Enable byte bit 0 enables keyboard requests and bit 1 enables display requests. Both are writable at offset 3. All other bits of the flag and enable bytes read 0.
- R9: Flag bit 2 is (bit 0 AND keyboard enable). Flag bit 3 is (bit 1 AND display enable). `irq` is the OR of bits 2 and 3.
- R10: Writes at offsets 0 and 2 have no effect.
- R11: If a keystroke arrives in the same cycle as a read at offset 0, the read returns the old character and flag bit 0 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus cycle valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when unclaimed |
| bus_hit | output | 1 | Cycle claimed by this block |
| kbd_data | input | 8 | Keyboard character |
| kbd_valid | input | 1 | One-cycle keystroke strobe |
| disp_data | output | 8 | Character for the display |
| disp_load | output | 1 | One-cycle strobe: new character on `disp_data` |
| disp_ready | input | 1 | Display can accept a character |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker assumes that `disp_ready` never rises in the same cycle as a write at offset 1. In that case the write takes priority and the rise is lost. It also assumes that the bus inputs are stable within a cycle. The bench drives every bus cycle, keystroke and ready change at the falling edge, one at a time. It moves `disp_ready` only in cycles with no bus write, so the stimulus stays inside these assumptions. A keystroke that coincides with a read of offset 0 is exercised on purpose, because the block defines that case (R11).

// File: rtl/kbdisp_port.sv
module kbdisp_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_hit,
  input  logic [7:0]        kbd_data,
  input  logic              kbd_valid,
  output logic [7:0]        disp_data,
  output logic              disp_load,
  input  logic              disp_ready,
  output logic              irq
);
  localparam int OFF_W = 2;

  logic [7:0]       rx_q, tx_q;
  logic             sin, sout, ovr, ken, den, rdy_q;
  logic [OFF_W-1:0] off;
  logic             rd_rx, rd_flags, wr_tx, wr_en;
  logic             kreq, dreq;

  assign bus_hit  = bus_sel && (bus_addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);
  assign off      = bus_addr[OFF_W-1:0];
  assign rd_rx    = bus_hit && !bus_wr && off == 2'd0;
  assign rd_flags = bus_hit && !bus_wr && off == 2'd2;
  assign wr_tx    = bus_hit &&  bus_wr && off == 2'd1;
  assign wr_en    = bus_hit &&  bus_wr && off == 2'd3;

  assign kreq = sin && ken;
  assign dreq = sout && den;
  assign irq  = kreq || dreq;
  assign disp_data = tx_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_hit && !bus_wr) begin
      unique case (off)
        2'd0: bus_rdata = rx_q;
        2'd1: bus_rdata = tx_q;
        2'd2: bus_rdata = {3'b000, ovr, dreq, kreq, sout, sin};
        2'd3: bus_rdata = {6'b000000, den, ken};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= '0;
      sin  <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (kbd_valid) begin
        rx_q <= kbd_data;
        sin  <= 1'b1;
      end else if (rd_rx) begin
        sin  <= 1'b0;
      end
      if (kbd_valid && sin) ovr <= 1'b1;
      else if (rd_flags)    ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q      <= '0;
      sout      <= 1'b0;
      rdy_q     <= 1'b0;
      disp_load <= 1'b0;
      ken       <= 1'b0;
      den       <= 1'b0;
    end else begin
      rdy_q     <= disp_ready;
      disp_load <= wr_tx;
      if (wr_tx) begin
        tx_q <= bus_wdata;
        sout <= 1'b0;
      end else if (disp_ready && !rdy_q) begin
        sout <= 1'b1;
      end
      if (wr_en) begin
        ken <= bus_wdata[0];
        den <= bus_wdata[1];
      end
    end
  end
endmodule

module kbdisp_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_sel,
  input logic bus_hit,
  input logic bus_wr,
  input logic [1:0] off,
  input logic kbd_valid,
  input logic sin,
  input logic sout,
  input logic ovr,
  input logic ken,
  input logic den,
  input logic disp_load,
  input logic irq,
  input logic [7:0] bus_rdata
);
  // R3
  kbd_sets_sin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid |=> sin);
  // R4
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hit && !bus_wr && off == 2'd0 && !kbd_valid) |=> !sin);
  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_valid && sin) |=> ovr);
  // R6
  tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hit && bus_wr && off == 2'd1) |=> (disp_load && !sout));
  // R6
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_load && !(bus_hit && bus_wr && off == 2'd1)) |=> !disp_load);
  // R2
  miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_hit) |=> ($stable(ken) && $stable(den)));
  // R2
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_hit) |-> bus_rdata == 8'h00);
  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ken || den));
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_valid && bus_hit && !bus_wr && off == 2'd0) |=> sin);
endmodule

bind kbdisp_port kbdisp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_hit(bus_hit), .bus_wr(bus_wr),
  .off(off), .kbd_valid(kbd_valid), .sin(sin), .sout(sout), .ovr(ovr), .ken(ken),
  .den(den), .disp_load(disp_load), .irq(irq), .bus_rdata(bus_rdata)
);

// File: tb/tb_kbdisp_port.sv
module tb_kbdisp_port;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0040;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic bus_hit;
  logic [7:0] kbd_data = '0, disp_data;
  logic kbd_valid = 0, disp_load, disp_ready = 1, irq;
  int errors = 0, checks = 0;

  kbdisp_port #(.ADDR_W(AW), .BASE(BASE)) dut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic kput(input logic [7:0] c);
    @(negedge clk); kbd_valid = 1; kbd_data = c;
    @(negedge clk); kbd_valid = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bread(BASE + 2, d); check("R1 flags in reset", d, 0);
    check("R1 irq in reset", irq, 0);
    check("R1 load in reset", disp_load, 0);
    @(negedge clk); rst_n = 1;
    bread(BASE + 3, d); check("R1 enables after reset", d, 0);
  endtask

  task automatic t_decode;
    logic [7:0] d;
    bwrite(BASE + 4, 8'h03);
    bwrite(BASE - 1, 8'h03);
    bread(BASE + 3, d); check("R2 miss writes nothing", d, 0);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = BASE + 4;
    #1 check("R2 miss hit", bus_hit, 0); check("R2 miss rdata", bus_rdata, 0);
    bus_addr = BASE + 3; #1 check("R2 top hit", bus_hit, 1);
    bus_sel = 0; #1 check("R2 sel low", bus_hit, 0);
  endtask

  task automatic t_kbd;
    logic [7:0] d;
    kput(8'h41);
    bread(BASE + 2, d); check("R3 sin set", d[0], 1);
    bread(BASE + 0, d); check("R4 char", d, 8'h41);
    bread(BASE + 2, d); check("R4 sin cleared", d[0], 0);
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    kput(8'h11); kput(8'h22);
    bread(BASE + 2, d); check("R5 ovr set", d[4], 1);
    bread(BASE + 2, d); check("R5 ovr cleared", d[4], 0);
    bread(BASE + 0, d); check("R5 overwritten", d, 8'h22);
  endtask

  task automatic t_setwins;
    logic [7:0] d;
    kput(8'h55);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = BASE; kbd_valid = 1; kbd_data = 8'h66;
    #1 check("R11 old char", bus_rdata, 8'h55);
    @(negedge clk); bus_sel = 0; kbd_valid = 0;
    bread(BASE + 2, d); check("R11 sin stays", d[0], 1);
    bread(BASE + 0, d); check("R11 new char", d, 8'h66);
    bread(BASE + 2, d); d[4] = 0; bread(BASE + 2, d);
  endtask

  task automatic t_display;
    logic [7:0] d;
    bread(BASE + 2, d); check("R7 sout after reset", d[1], 1);
    bwrite(BASE + 1, 8'h7A);
    check("R6 load pulse", disp_load, 1); check("R6 data", disp_data, 8'h7A);
    @(negedge clk); check("R6 load one cycle", disp_load, 0);
    bread(BASE + 2, d); check("R6 sout cleared", d[1], 0);
    @(negedge clk); disp_ready = 0;
    @(negedge clk); @(negedge clk);
    bread(BASE + 2, d); check("R7 still busy", d[1], 0);
    disp_ready = 1;
    @(negedge clk); #1;
    bread(BASE + 2, d); check("R7 sout on rise", d[1], 1);
  endtask

  task automatic t_control;
    logic [7:0] d;
    bwrite(BASE + 3, 8'hFF);
    bread(BASE + 3, d); check("R8 enables", d, 8'h03);
    bwrite(BASE + 3, 8'h00);
    bread(BASE + 3, d); check("R8 cleared", d, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    bwrite(BASE + 3, 8'h01);
    check("R9 no irq yet", irq, 0);
    kput(8'h30);
    check("R9 kbd irq", irq, 1);
    bread(BASE + 2, d); check("R9 flags kbd", d, 8'h07);
    bread(BASE + 0, d); check("R9 irq drop", irq, 0);
    bwrite(BASE + 3, 8'h02);
    check("R9 disp irq", irq, 1);
    bread(BASE + 2, d); check("R9 flags disp", d, 8'h0A);
    bwrite(BASE + 1, 8'h31);
    check("R9 disp irq drop", irq, 0);
    @(negedge clk); disp_ready = 0; @(negedge clk); disp_ready = 1; @(negedge clk);
    bwrite(BASE + 3, 8'h00);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    kput(8'h42);
    bwrite(BASE + 0, 8'h99);
    bwrite(BASE + 2, 8'h00);
    bread(BASE + 2, d); check("R10 flags kept", d, 8'h03);
    bread(BASE + 0, d); check("R10 char kept", d, 8'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset; t_decode; t_kbd; t_overrun; t_setwins;
    t_display; t_control; t_irq; t_ignored;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule